// File: doc/BRIEF.md
# Staggered Half-Rate Scan Clock Enable Generator

This block splits a scan path into two groups of cells, A and B, and produces a clock enable for each group. In shift mode the two enables take turns: group A is enabled in one system-clock cycle and group B in the next. Each group therefore shifts at half the system rate, and the two groups are never active in the same cycle. This halves the number of cells that can toggle on any edge. When scan enable is low (capture or functional mode), both enables stay high and every cell is clocked on every edge.

One phase flip-flop sets the alternation. The same flip-flop drives the select line of an output multiplexer, so the scan-out pin shows group A's last cell in A cycles and group B's last cell in B cycles. The serial input feeds both groups. Because the groups interleave, a full scan pass of 2·GRP_LEN cells takes 2·GRP_LEN cycles, the same as one conventional chain of that length.

The enables are synchronous: each group's cells load only on edges where their enable is high. The block includes a behavioural model of the two groups and the output multiplexer, so the whole path can be checked from the serial input to the serial output.

Top module: `stag_scan_clk_gen`

## Requirements
- R1: While rst_ni is low, the phase is reset to group A and every cell of both groups is cleared to 0.
- R2: In every cycle with scan_en_i high, exactly one of en_a_o and en_b_o is high, and the high enable changes from one cycle to the next while scan_en_i stays high.
- R3: While scan_en_i is low, both en_a_o and en_b_o are high and out_sel_o is 0. On each clock edge, group A loads cap_a_i and group B loads cap_b_i in parallel.
- R4: With scan_en_i high, out_sel_o equals en_b_o (1 selects group B). scan_out_o always shows the last cell (index GRP_LEN-1) of the group that out_sel_o selects.
- R5: On an edge in shift mode, the enabled group shifts: cell 0 takes scan_in_i and cell k takes cell k-1. The other group holds its contents.
- R6: The first shift cycle after scan_en_i rises, after any number of capture cycles and after a shift burst of any length (odd or even), enables group A.
- R7: In a shift burst that starts in phase A, the bit applied to scan_in_i in shift cycle t appears on scan_out_o in shift cycle t+2·GRP_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | 1 = shift mode, 0 = capture or functional mode |
| scan_in_i | input | 1 | Serial scan input, shared by both groups |
| cap_a_i | input | GRP_LEN | Capture data for group A |
| cap_b_i | input | GRP_LEN | Capture data for group B |
| en_a_o | output | 1 | Clock enable for group A |
| en_b_o | output | 1 | Clock enable for group B |
| out_sel_o | output | 1 | Output select, 1 = group B |
| scan_out_o | output | 1 | Serial scan output |
| q_a_o | output | GRP_LEN | Cell contents of group A |
| q_b_o | output | GRP_LEN | Cell contents of group B |

## Verification
A phase flip-flop that is wrong shows up on the enable and select pins in the same cycle: both enables high, no alternation, or group B going first after scan_en_i rises. The cell contents go wrong one edge later. A wrong shift or hold decision in a group changes q_a_o or q_b_o right after the edge that caused it. On the serial path, the error reaches scan_out_o once the corrupted bit has moved through the remaining cells, which takes at most 2·GRP_LEN shift cycles. The bench predicts the phase and both groups every cycle, so each kind of fault is caught at the earliest pin where it appears.

// File: rtl/stag_scan_pkg.sv
package stag_scan_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;
endpackage

// File: rtl/stag_phase_gen.sv
module stag_phase_gen
  import stag_scan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  output logic en_a_o,
  output logic en_b_o,
  output logic sel_o
);
  phase_e ph_q;

  // held at A outside shift, so every shift burst starts with group A
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= PH_A;
    else if (!shift_i) ph_q <= PH_A;
    else               ph_q <= (ph_q == PH_A) ? PH_B : PH_A;
  end

  always_comb begin
    en_a_o = !shift_i || (ph_q == PH_A);
    en_b_o = !shift_i || (ph_q == PH_B);
    sel_o  = shift_i && (ph_q == PH_B);
  end
endmodule

// File: rtl/stag_scan_group.sv
module stag_scan_group #(
  parameter int unsigned LEN = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           shift_i,
  input  logic           si_i,
  input  logic [LEN-1:0] cap_i,
  output logic [LEN-1:0] q_o,
  output logic           tail_o
);
  logic [LEN-1:0] src;

  for (genvar k = 0; k < LEN; k++) begin : g_cell
    if (k == 0) begin : g_head
      assign src[k] = shift_i ? si_i : cap_i[k];
    end else begin : g_body
      assign src[k] = shift_i ? q_o[k-1] : cap_i[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[k] <= 1'b0;
      else if (en_i) q_o[k] <= src[k];
    end
  end

  assign tail_o = q_o[LEN-1];
endmodule

// File: rtl/stag_out_mux.sv
module stag_out_mux (
  input  logic sel_i,
  input  logic a_i,
  input  logic b_i,
  output logic so_o
);
  assign so_o = sel_i ? b_i : a_i;
endmodule

// File: rtl/stag_scan_clk_gen.sv
module stag_scan_clk_gen #(
  parameter int unsigned GRP_LEN = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scan_en_i,
  input  logic               scan_in_i,
  input  logic [GRP_LEN-1:0] cap_a_i,
  input  logic [GRP_LEN-1:0] cap_b_i,
  output logic               en_a_o,
  output logic               en_b_o,
  output logic               out_sel_o,
  output logic               scan_out_o,
  output logic [GRP_LEN-1:0] q_a_o,
  output logic [GRP_LEN-1:0] q_b_o
);
  logic tail_a, tail_b;

  stag_phase_gen i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(scan_en_i),
    .en_a_o (en_a_o),
    .en_b_o (en_b_o),
    .sel_o  (out_sel_o)
  );

  stag_scan_group #(.LEN(GRP_LEN)) i_grp_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_a_o),
    .shift_i(scan_en_i),
    .si_i   (scan_in_i),
    .cap_i  (cap_a_i),
    .q_o    (q_a_o),
    .tail_o (tail_a)
  );

  stag_scan_group #(.LEN(GRP_LEN)) i_grp_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_b_o),
    .shift_i(scan_en_i),
    .si_i   (scan_in_i),
    .cap_i  (cap_b_i),
    .q_o    (q_b_o),
    .tail_o (tail_b)
  );

  stag_out_mux i_mux (
    .sel_i(out_sel_o),
    .a_i  (tail_a),
    .b_i  (tail_b),
    .so_o (scan_out_o)
  );
endmodule

// File: rtl/stag_scan_clk_gen_chk.sv
module stag_scan_clk_gen_chk #(
  parameter int unsigned GRP_LEN = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scan_en_i,
  input logic               scan_in_i,
  input logic [GRP_LEN-1:0] cap_a_i,
  input logic [GRP_LEN-1:0] cap_b_i,
  input logic               en_a_o,
  input logic               en_b_o,
  input logic               out_sel_o,
  input logic               scan_out_o,
  input logic [GRP_LEN-1:0] q_a_o,
  input logic [GRP_LEN-1:0] q_b_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  one_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |-> (en_a_o != en_b_o));

  // R2
  alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && scan_en_i && $past(scan_en_i)) |-> (en_a_o != $past(en_a_o)));

  // R3
  capture_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |-> (en_a_o && en_b_o && !out_sel_o));

  // R3
  capture_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(scan_en_i)) |-> (q_a_o == $past(cap_a_i) && q_b_o == $past(cap_b_i)));

  // R4
  sel_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |-> (out_sel_o == en_b_o));

  // R5
  hold_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(scan_en_i && !en_a_o)) |-> (q_a_o == $past(q_a_o)));

  // R5
  hold_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(scan_en_i && !en_b_o)) |-> (q_b_o == $past(q_b_o)));

  // R6
  start_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(scan_en_i)) |-> (en_a_o && !en_b_o));
endmodule

bind stag_scan_clk_gen stag_scan_clk_gen_chk #(.GRP_LEN(GRP_LEN)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scan_en_i (scan_en_i),
  .scan_in_i (scan_in_i),
  .cap_a_i   (cap_a_i),
  .cap_b_i   (cap_b_i),
  .en_a_o    (en_a_o),
  .en_b_o    (en_b_o),
  .out_sel_o (out_sel_o),
  .scan_out_o(scan_out_o),
  .q_a_o     (q_a_o),
  .q_b_o     (q_b_o)
);

// File: tb/test_stag_scan_clk_gen.sv
module test_stag_scan_clk_gen;
  localparam int unsigned GL = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          scan_en_i = 1'b0;
  logic          scan_in_i = 1'b0;
  logic [GL-1:0] cap_a_i = '0;
  logic [GL-1:0] cap_b_i = '0;
  logic          en_a_o, en_b_o, out_sel_o, scan_out_o;
  logic [GL-1:0] q_a_o, q_b_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of phase (0 = A) and group contents
  logic          m_ph = 1'b0;
  logic [GL-1:0] m_qa = '0;
  logic [GL-1:0] m_qb = '0;

  stag_scan_clk_gen #(.GRP_LEN(GL)) i_stag_scan_clk_gen (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [GL-1:0] act, input logic [GL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_en_a(input logic se, input logic ph);
    return !se || !ph;
  endfunction

  function automatic logic exp_en_b(input logic se, input logic ph);
    return !se || ph;
  endfunction

  // one cycle: inputs set after negedge, outputs checked, edge applied, state checked
  task automatic cycle(input logic se, input logic si, input logic [GL-1:0] ca,
                       input logic [GL-1:0] cb, output logic so);
    scan_en_i = se; scan_in_i = si; cap_a_i = ca; cap_b_i = cb;
    #1;
    chk("R2/R3 en_a", en_a_o, exp_en_a(se, m_ph));
    chk("R2/R3 en_b", en_b_o, exp_en_b(se, m_ph));
    chk("R4 sel", out_sel_o, se && m_ph);
    chk("R4 scan_out", scan_out_o, (se && m_ph) ? m_qb[GL-1] : m_qa[GL-1]);
    so = scan_out_o;
    if (!se) begin
      m_qa = ca; m_qb = cb; m_ph = 1'b0;
    end else begin
      if (!m_ph) m_qa = {m_qa[GL-2:0], si};
      else       m_qb = {m_qb[GL-2:0], si};
      m_ph = ~m_ph;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(se ? "R5 group A" : "R3 group A", q_a_o, m_qa);
    chk(se ? "R5 group B" : "R3 group B", q_b_o, m_qb);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic so;
    logic [2*GL-1:0] pat;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    // R1: reset state
    chk("R1 group A", q_a_o, '0);
    chk("R1 group B", q_b_o, '0);
    chk("R1 en_a", en_a_o, 1'b1);
    chk("R1 sel", out_sel_o, 1'b0);
    scan_en_i = 1'b1;
    #1;
    chk("R1 phase A first", en_a_o, 1'b1);
    chk("R1 phase B idle", en_b_o, 1'b0);
    scan_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7: full load then unload, conventional chain latency
    cycle(1'b0, 1'b0, '0, '0, so);
    pat = {$urandom, $urandom};
    for (int t = 0; t < 2 * GL; t++) cycle(1'b1, pat[t], '0, '0, so);
    for (int t = 0; t < 2 * GL; t++) begin
      cycle(1'b1, 1'b0, '0, '0, so);
      chk("R7 stream", so, pat[t]);
    end

    // R6: odd burst, capture, re-entry starts at A
    cycle(1'b0, 1'b0, 8'hA5, 8'h3C, so);
    for (int t = 0; t < 3; t++) cycle(1'b1, 1'b1, '0, '0, so);
    cycle(1'b0, 1'b0, 8'hFF, 8'h00, so);
    scan_en_i = 1'b1;
    #1;
    chk("R6 re-entry en_a", en_a_o, 1'b1);
    chk("R6 re-entry en_b", en_b_o, 1'b0);
    @(negedge clk_i);
    scan_en_i = 1'b0;
    m_qa = 8'hFF; m_qb = 8'h00; m_ph = 1'b0;
    cycle(1'b0, 1'b0, 8'h81, 8'h7E, so);

    // R2/R3/R4/R5/R6: random bursts of random length
    for (int b = 0; b < 400; b++) begin
      int len;
      logic se;
      len = 1 + ($urandom % 9);
      se  = ($urandom % 3) != 0;
      for (int t = 0; t < len; t++)
        cycle(se, 1'($urandom), GL'($urandom), GL'($urandom), so);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule